// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is an 8-bit arithmetic-logic unit wrapped around a single accumulator register. On each cycle where the start strobe is high, it combines the accumulator with the operand byte according to the operation select. The result goes back into the accumulator. Five status flags are updated at the same clock edge.

The block supports these operations:

- binary add and subtract, each with or without the incoming carry or borrow;
- bitwise AND, OR and XOR;
- a compare that sets flags only;
- four rotates of the accumulator;
- a decimal-adjust step that corrects the accumulator after two packed-BCD bytes have been added.

The block is meant to sit under an instruction decoder that already knows which operation to issue and where the operand byte comes from. To load a value, the decoder clears the accumulator with an AND of zero and then ORs in the value. The flags are exported so that conditional branches in the surrounding control logic can test them.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted (rst_n low) the accumulator and all five flags read zero, and they stay zero after reset is released until the first strobed operation.
- R2: A cycle with start low changes neither the accumulator nor any flag. Operation codes 13, 14 and 15 are no-ops even with start high.
- R3: Codes 0 (add) and 1 (add with carry) store acc + operand (+ C for code 1) modulo 256. C is set to the carry out of bit 7 and AC to the carry out of bit 3.
- R4: Codes 2 (subtract) and 3 (subtract with borrow) store acc - operand (- C for code 3) modulo 256. C is set when the full subtraction borrows. AC is set when the low-nibble subtraction borrows.
- R5: Code 7 (compare) sets C, AC, Z, S and P exactly as code 2 would, but leaves the accumulator unchanged.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) store the bitwise result, clear C and AC, and set Z, S and P from the result.
- R7: The rotates change only the accumulator and C; AC, Z, S and P keep their values. The four rotates are:
  - Code 8 rotates left, with bit 7 going to bit 0 and into C.
  - Code 9 rotates right, with bit 0 going to bit 7 and into C.
  - Code 10 rotates left through C: the old C enters bit 0 and bit 7 goes into C.
  - Code 11 rotates right through C: the old C enters bit 7 and bit 0 goes into C.
- R8: Code 12 (decimal adjust), low nibble: 6 is added to the accumulator when AC is set, or when bits 3 and 2 are both set, or when bits 3 and 1 are both set. AC is then set only if this correction carried out of bit 3.
- R9: Code 12, high nibble: after the low-nibble step, 0x60 is added when C is set, when the low-nibble correction carried out of bit 7, or when bits 7 and 6 or bits 7 and 5 are both set. C is kept if already set, and is also set by any carry out of bit 7 during the adjust.
- R10: For codes 0 to 7 and 12, Z is set when the 8-bit result is zero, S equals result bit 7, and P is set when the result holds an even number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Second operand byte |
| start | input | 1 | Perform the selected operation at this edge |
| acc | output | 8 | Accumulator contents |
| flag_c | output | 1 | Carry / borrow flag |
| flag_ac | output | 1 | Auxiliary carry out of the low nibble |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even-parity flag |

## Verification
Every result lands in the accumulator and the flags one edge after the strobe, so a wrong carry or auxiliary carry stays hidden until a later operation consumes it. That later operation can be an add or subtract with carry, a rotate through carry, or a decimal adjust. The stimulus is therefore a dependent chain in which each flag is consumed by a following step, so a corrupted flag shows up at the ports within one or two operations. Decimal adjust is driven by:

- the nibble-range test alone;
- the auxiliary carry alone;
- a carry that was already set with an in-range high nibble.

Each of these exposes a different missing correction term on the very next cycle.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] operand,
  input  logic          start,
  output logic [DW-1:0] acc,
  output logic          flag_c,
  output logic          flag_ac,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_p
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMP = 4'd7;
  localparam logic [3:0] OP_RL  = 4'd8,  OP_RR  = 4'd9,  OP_RLC = 4'd10, OP_RRC = 4'd11;
  localparam logic [3:0] OP_DAA = 4'd12;
  localparam int MSB = DW - 1;

  logic [DW-1:0] acc_q;
  logic c_q, ac_q, z_q, s_q, p_q;

  logic          is_sub, use_cin, cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;
  logic          nib_carry;

  assign is_sub  = (op_sel == OP_SUB) || (op_sel == OP_SBB) || (op_sel == OP_CMP);
  assign use_cin = (op_sel == OP_ADC) || (op_sel == OP_SBB);
  assign b_eff   = is_sub ? ~operand : operand;
  assign cin     = is_sub ? ~(use_cin & c_q) : (use_cin & c_q);
  assign sum     = {1'b0, acc_q} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  assign nib_carry = acc_q[4] ^ b_eff[4] ^ sum[4];

  logic          lo_fix, hi_fix;
  logic [DW:0]   adj1, adj2;
  logic [3:0]    hi_nib;

  assign lo_fix = (acc_q[3] & (acc_q[2] | acc_q[1])) | ac_q;
  assign adj1   = {1'b0, acc_q} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_nib = adj1[7:4];
  assign hi_fix = (hi_nib[3] & (hi_nib[2] | hi_nib[1])) | c_q | adj1[DW];
  assign adj2   = {1'b0, adj1[DW-1:0]} + (hi_fix ? 9'h060 : 9'h000);

  logic [DW-1:0] res;
  logic          nc, nac, upd_zsp, wr_acc, act;

  always_comb begin
    res     = acc_q;
    nc      = c_q;
    nac     = ac_q;
    upd_zsp = 1'b0;
    wr_acc  = 1'b0;
    act     = 1'b1;
    case (op_sel)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res     = sum[DW-1:0];
        nc      = sum[DW] ^ is_sub;
        nac     = nib_carry ^ is_sub;
        upd_zsp = 1'b1;
        wr_acc  = (op_sel != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR: begin
        res     = (op_sel == OP_AND) ? (acc_q & operand) :
                  (op_sel == OP_OR)  ? (acc_q | operand) : (acc_q ^ operand);
        nc      = 1'b0;
        nac     = 1'b0;
        upd_zsp = 1'b1;
        wr_acc  = 1'b1;
      end
      OP_RL: begin
        res    = {acc_q[MSB-1:0], acc_q[MSB]};
        nc     = acc_q[MSB];
        wr_acc = 1'b1;
      end
      OP_RR: begin
        res    = {acc_q[0], acc_q[MSB:1]};
        nc     = acc_q[0];
        wr_acc = 1'b1;
      end
      OP_RLC: begin
        res    = {acc_q[MSB-1:0], c_q};
        nc     = acc_q[MSB];
        wr_acc = 1'b1;
      end
      OP_RRC: begin
        res    = {c_q, acc_q[MSB:1]};
        nc     = acc_q[0];
        wr_acc = 1'b1;
      end
      OP_DAA: begin
        res     = adj2[DW-1:0];
        nc      = c_q | adj1[DW] | adj2[DW];
        nac     = lo_fix & (acc_q[3:0] >= 4'd10);
        upd_zsp = 1'b1;
        wr_acc  = 1'b1;
      end
      default: act = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      c_q   <= 1'b0;
      ac_q  <= 1'b0;
      z_q   <= 1'b0;
      s_q   <= 1'b0;
      p_q   <= 1'b0;
    end else if (start && act) begin
      if (wr_acc) acc_q <= res;
      c_q  <= nc;
      ac_q <= nac;
      if (upd_zsp) begin
        z_q <= (res == '0);
        s_q <= res[MSB];
        p_q <= ~^res;
      end
    end
  end

  assign acc     = acc_q;
  assign flag_c  = c_q;
  assign flag_ac = ac_q;
  assign flag_z  = z_q;
  assign flag_s  = s_q;
  assign flag_p  = p_q;

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(acc) && $stable({flag_c, flag_ac, flag_z, flag_s, flag_p}));

  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == OP_CMP) |=> $stable(acc));

  a_r6_logic_clears_carries: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)) |=> !flag_c && !flag_ac);

  a_r7_rotate_keeps_zsp: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel >= OP_RL && op_sel <= OP_RRC) |=> $stable({flag_ac, flag_z, flag_s, flag_p}));

  a_r7_rl_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == OP_RL) |=> acc == {$past(acc[MSB-1:0]), $past(acc[MSB])} && flag_c == $past(acc[MSB]));

  a_r9_daa_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == OP_DAA && flag_c) |=> flag_c);

  a_r10_zsp_track_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_sel <= OP_XOR || op_sel == OP_DAA)) |=>
      flag_z == (acc == '0) && flag_s == acc[MSB] && flag_p == ~^acc);
endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op_sel;
  logic [7:0] operand;
  logic       start;
  logic [7:0] acc;
  logic       flag_c, flag_ac, flag_z, flag_s, flag_p;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand), .start(start),
    .acc(acc), .flag_c(flag_c), .flag_ac(flag_ac), .flag_z(flag_z),
    .flag_s(flag_s), .flag_p(flag_p)
  );

  // {req[3:0], op[3:0], operand[7:0], exp_acc[7:0], exp_flags{C,AC,Z,S,P}}
  localparam int NV = 28;
  localparam logic [28:0] VEC [0:NV-1] = '{
    {4'd3,  4'd0,  8'h15, 8'h15, 5'b00000},  // R3 add
    {4'd10, 4'd0,  8'h27, 8'h3C, 5'b00001},  // R10 even parity
    {4'd8,  4'd12, 8'h00, 8'h42, 5'b01001},  // R8 range test on low nibble
    {4'd10, 4'd0,  8'h99, 8'hDB, 5'b00011},  // R10 sign
    {4'd9,  4'd12, 8'h00, 8'h41, 5'b11001},  // R9 high nibble fix, carry out
    {4'd3,  4'd1,  8'h00, 8'h42, 5'b00001},  // R3 add with carry
    {4'd4,  4'd2,  8'h42, 8'h00, 5'b00101},  // R4 subtract to zero
    {4'd4,  4'd2,  8'h01, 8'hFF, 5'b11011},  // R4 borrow
    {4'd4,  4'd3,  8'h0F, 8'hEF, 5'b01010},  // R4 subtract with borrow
    {4'd5,  4'd7,  8'hF0, 8'hEF, 5'b10011},  // R5 compare
    {4'd6,  4'd4,  8'h3C, 8'h2C, 5'b00000},  // R6 and
    {4'd6,  4'd5,  8'h81, 8'hAD, 5'b00010},  // R6 or
    {4'd6,  4'd6,  8'hAD, 8'h00, 5'b00101},  // R6 xor
    {4'd6,  4'd5,  8'h81, 8'h81, 5'b00011},  // R6 or
    {4'd7,  4'd8,  8'h00, 8'h03, 5'b10011},  // R7 rotate left
    {4'd7,  4'd11, 8'h00, 8'h81, 5'b10011},  // R7 right through carry
    {4'd7,  4'd9,  8'h00, 8'hC0, 5'b10011},  // R7 rotate right
    {4'd7,  4'd10, 8'h00, 8'h81, 5'b10011},  // R7 left through carry
    {4'd6,  4'd4,  8'hFE, 8'h80, 5'b00010},  // R6 and
    {4'd7,  4'd10, 8'h00, 8'h00, 5'b10010},  // R7 left through carry, Z held
    {4'd7,  4'd11, 8'h00, 8'h80, 5'b00010},  // R7 right through carry
    {4'd2,  4'd13, 8'h55, 8'h80, 5'b00010},  // R2 unused code
    {4'd3,  4'd0,  8'h80, 8'h00, 5'b10101},  // R3 carry out of bit 7
    {4'd9,  4'd12, 8'h00, 8'h60, 5'b10001},  // R9 prior carry forces high fix
    {4'd6,  4'd4,  8'h00, 8'h00, 5'b00101},  // R6 clear
    {4'd6,  4'd5,  8'h09, 8'h09, 5'b00001},  // R6 load via or
    {4'd3,  4'd0,  8'h09, 8'h12, 5'b01001},  // R3 aux carry
    {4'd8,  4'd12, 8'h00, 8'h18, 5'b00001}   // R8 aux carry drives low fix
  };

  task automatic check(input int req, input logic [7:0] ea, input logic [4:0] ef);
    logic [4:0] af;
    af = {flag_c, flag_ac, flag_z, flag_s, flag_p};
    n_chk++;
    if (acc !== ea || af !== ef) begin
      n_bad++;
      $display("FAIL R%0d: acc=%02h flags=%05b expected acc=%02h flags=%05b", req, acc, af, ea, ef);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] b, input logic strobe);
    @(negedge clk);
    op_sel  = op;
    operand = b;
    start   = strobe;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    op_sel = 4'd0;
    operand = 8'h00;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 8'h00, 5'b00000);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 8'h00, 5'b00000);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][24:21], VEC[i][20:13], 1'b1);
      check(int'(VEC[i][28:25]), VEC[i][12:5], VEC[i][4:0]);
    end

    // R2: strobe low leaves everything alone
    do_op(4'd0, 8'h77, 1'b0);
    check(2, 8'h18, 5'b00001);
    // R2: codes 14 and 15 do nothing
    do_op(4'd14, 8'hFF, 1'b1);
    check(2, 8'h18, 5'b00001);
    do_op(4'd15, 8'hFF, 1'b1);
    check(2, 8'h18, 5'b00001);

    // R9: low fix carries out of bit 7 (0xFA + 6) -> high fix too
    do_op(4'd4, 8'h00, 1'b1);
    do_op(4'd5, 8'hFA, 1'b1);
    check(6, 8'hFA, 5'b00011);
    do_op(4'd12, 8'h00, 1'b1);
    check(9, 8'h60, 5'b11001);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 8'h00, 5'b00000);

    finish_run();
  end
endmodule